// File: doc/BRIEF.md
# Sequential Integer Divider with Early Termination

This block divides one integer by another and returns both the quotient and the remainder. Operands are two's complement in signed mode and plain binary in unsigned mode. It resolves one quotient bit per clock with a restoring subtract-and-shift step. Before the loop starts, it looks at how many leading bits of the dividend are only sign or zero fill. It then skips the loop passes that could only produce leading zero quotient bits. The skipped passes are treated as already done, so the result is the same as a full-length run.

Signed division is done on magnitudes. An optional cycle before the loop takes the absolute values of negative operands. An optional cycle after the loop negates the quotient or the remainder when needed.

The caller pulses `start` with the operands and the mode. The caller must not issue again until `done` has pulsed. The results stay on the outputs until the next result replaces them.

Top module: `seqdiv_early`

## Requirements
- R1: With `sgn_mode`=0, the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor, both read as unsigned WIDTH-bit values, for any nonzero divisor.
- R2: With `sgn_mode`=1, the operands are two's complement. The quotient truncates toward zero and a nonzero remainder takes the dividend's sign. The most negative dividend divided by -1 gives the most negative value as quotient and 0 as remainder.
- R3: A zero divisor gives an all-ones quotient and a remainder equal to the dividend in both modes. It never adds an output fixup cycle.
- R4: The loop runs WIDTH passes when the dividend has no skippable fill. An unsigned full-width divide with WIDTH=32 raises `done` 33 clock edges after the edge that accepts `start` (latency = 1 + passes + fixup cycles).
- R5: Let n be the smallest value in 1..WIDTH/CHUNK-1 for which the dividend fits in n*CHUNK bits (unsigned), or in n*CHUNK bits two's complement (signed). The loop then runs n*CHUNK+1 passes. With WIDTH=32 and CHUNK=8, that skips 23, 15 or 7 passes.
- R6: In signed mode, one input fixup cycle is added when either operand is negative. One output fixup cycle is added when the divisor is nonzero and either of two cases holds: the operand signs differ with a nonzero quotient magnitude, or the dividend is negative with a nonzero remainder. Unsigned mode adds neither cycle.
- R7: `done` is high for exactly one cycle, in the same cycle that the new quotient and remainder first appear. The outputs do not change at any other time.
- R8: `busy` rises in the cycle after `start` is accepted and falls in the `done` cycle. A `start` pulse while `busy` is high is ignored and does not change the running result.
- R9: After synchronous reset, `busy` and `done` are low and both result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| sgn_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled with `start` |
| divisor | input | WIDTH | Divisor, sampled with `start` |
| busy | output | 1 | A division is running |
| done | output | 1 | One-cycle pulse marking new results |
| quotient | output | WIDTH | Quotient, held until the next result |
| remainder | output | WIDTH | Remainder, held until the next result |

## Verification
The bench builds one instance with WIDTH=8 and CHUNK=2. At that size every dividend can be swept against a spread of divisors in both modes. That covers all four pass counts, every sign combination, the overflow case and the zero divisor, with exact latency checked against the arithmetic model. A second instance at WIDTH=32 and CHUNK=8 checks the 33-cycle full latency, the 23/15/7 pass skips, and the rule that a start pulse is ignored while busy.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FIX_IN  = 3'd1,
    ST_STEP    = 3'd2,
    ST_FIX_OUT = 3'd3,
    ST_OUT     = 3'd4
  } seqdiv_state_e;

endpackage

// File: rtl/seqdiv_width_probe.sv
// Finds how many loop passes a dividend needs, from its leading fill.
module seqdiv_width_probe #(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0]              value,
  input  logic                          sgn,
  output logic [$clog2(WIDTH+1)-1:0]    iters
);
  localparam int NCH = WIDTH / CHUNK;
  localparam int CW  = $clog2(WIDTH+1);

  logic [NCH-2:0] fits;

  generate
    for (genvar n = 1; n < NCH; n++) begin : g_tier
      logic fill_sgn;
      logic fill_uns;
      // two's complement fit: the top bits down to the new sign bit agree
      assign fill_sgn = (&value[WIDTH-1:n*CHUNK-1]) | ~(|value[WIDTH-1:n*CHUNK-1]);
      assign fill_uns = ~(|value[WIDTH-1:n*CHUNK]);
      assign fits[n-1] = sgn ? fill_sgn : fill_uns;
    end
  endgenerate

  always_comb begin
    iters = CW'(WIDTH);
    for (int n = NCH - 1; n >= 1; n--) begin
      if (fits[n-1]) iters = CW'(n * CHUNK + 1);
    end
  end
endmodule

// File: rtl/seqdiv_step.sv
// One restoring pass: shift a dividend bit in, subtract when it fits.
module seqdiv_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] part_rem,
  input  logic             in_bit,
  input  logic [WIDTH-1:0] dvsr,
  output logic [WIDTH-1:0] rem_nxt,
  output logic             q_bit
);
  logic [WIDTH:0]   trial;
  logic [WIDTH-1:0] low_diff;

  always_comb begin
    trial    = {part_rem, in_bit};
    q_bit    = (trial >= {1'b0, dvsr});
    low_diff = trial[WIDTH-1:0] - dvsr;
    rem_nxt  = q_bit ? low_diff : trial[WIDTH-1:0];
  end
endmodule

// File: rtl/seqdiv_cond_neg.sv
// Two's complement negation under an enable.
module seqdiv_cond_neg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] v,
  input  logic             en,
  output logic [WIDTH-1:0] y
);
  assign y = en ? (~v + WIDTH'(1)) : v;
endmodule

// File: rtl/seqdiv_early.sv
module seqdiv_early
  import seqdiv_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sgn_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int CW = $clog2(WIDTH+1);
  localparam logic [CW-1:0] W_CNT = CW'(WIDTH);

  seqdiv_state_e    state;
  logic [WIDTH-1:0] a_raw, b_raw;
  logic             a_neg, b_neg, sgn_r, dz;
  logic             fq, fr;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] a_sh;
  logic [WIDTH-1:0] dv;
  logic [WIDTH-1:0] part;
  logic [WIDTH-1:0] quot_q, rem_q;
  logic             done_q;

  logic [CW-1:0]    probe_iters;
  logic [WIDTH-1:0] a_abs, b_abs, q_fixed, r_fixed;
  logic [WIDTH-1:0] rem_nxt;
  logic             q_bit;
  logic [WIDTH-1:0] q_next;
  logic             need_fix_in;
  logic             fix_q_nxt, fix_r_nxt;

  seqdiv_width_probe #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_probe (
    .value (dividend),
    .sgn   (sgn_mode),
    .iters (probe_iters)
  );

  seqdiv_cond_neg #(.WIDTH(WIDTH)) u_abs_a (.v(a_raw), .en(a_neg), .y(a_abs));
  seqdiv_cond_neg #(.WIDTH(WIDTH)) u_abs_b (.v(b_raw), .en(b_neg), .y(b_abs));
  seqdiv_cond_neg #(.WIDTH(WIDTH)) u_fix_q (.v(a_sh),  .en(fq),    .y(q_fixed));
  seqdiv_cond_neg #(.WIDTH(WIDTH)) u_fix_r (.v(part),  .en(fr),    .y(r_fixed));

  seqdiv_step #(.WIDTH(WIDTH)) u_step (
    .part_rem (part),
    .in_bit   (a_sh[WIDTH-1]),
    .dvsr     (dv),
    .rem_nxt  (rem_nxt),
    .q_bit    (q_bit)
  );

  always_comb begin
    q_next      = {a_sh[WIDTH-2:0], q_bit};
    need_fix_in = sgn_mode & (dividend[WIDTH-1] | divisor[WIDTH-1]);
    fix_q_nxt   = sgn_r & ~dz & (a_neg ^ b_neg) & (|q_next);
    fix_r_nxt   = sgn_r & ~dz & a_neg & (|rem_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      a_raw  <= '0;
      b_raw  <= '0;
      a_neg  <= 1'b0;
      b_neg  <= 1'b0;
      sgn_r  <= 1'b0;
      dz     <= 1'b0;
      fq     <= 1'b0;
      fr     <= 1'b0;
      cnt    <= '0;
      a_sh   <= '0;
      dv     <= '0;
      part   <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            a_raw <= dividend;
            b_raw <= divisor;
            sgn_r <= sgn_mode;
            a_neg <= sgn_mode & dividend[WIDTH-1];
            b_neg <= sgn_mode & divisor[WIDTH-1];
            dz    <= (divisor == '0);
            cnt   <= probe_iters;
            part  <= '0;
            if (need_fix_in) begin
              state <= ST_FIX_IN;
            end else begin
              a_sh  <= dividend << (W_CNT - probe_iters);
              dv    <= divisor;
              state <= ST_STEP;
            end
          end
        end
        ST_FIX_IN: begin
          a_sh  <= a_abs << (W_CNT - cnt);
          dv    <= b_abs;
          state <= ST_STEP;
        end
        ST_STEP: begin
          a_sh <= q_next;
          part <= rem_nxt;
          cnt  <= cnt - CW'(1);
          if (cnt == CW'(1)) begin
            fq    <= fix_q_nxt;
            fr    <= fix_r_nxt;
            state <= (fix_q_nxt | fix_r_nxt) ? ST_FIX_OUT : ST_OUT;
          end
        end
        ST_FIX_OUT: begin
          a_sh  <= q_fixed;
          part  <= r_fixed;
          state <= ST_OUT;
        end
        ST_OUT: begin
          quot_q <= dz ? '1 : a_sh;
          rem_q  <= dz ? a_raw : part;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quot_q;
  assign remainder = rem_q;
endmodule

// File: rtl/seqdiv_early_chk.sv
module seqdiv_early_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sgn_mode,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic             cap_dz, cap_ovf;
  logic [WIDTH-1:0] cap_a;
  logic [15:0]      run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dz  <= 1'b0;
      cap_ovf <= 1'b0;
      cap_a   <= '0;
      run_cnt <= '0;
    end else begin
      if (start && !busy) begin
        cap_dz  <= (divisor == '0);
        cap_ovf <= sgn_mode && (dividend == MOST_NEG) && (divisor == '1);
        cap_a   <= dividend;
      end
      run_cnt <= busy ? run_cnt + 16'd1 : 16'd0;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_div_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (done && cap_dz) |-> (quotient == '1 && remainder == cap_a));

  assert_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (done && cap_ovf) |-> (quotient == MOST_NEG && remainder == '0));

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt <= 16'(WIDTH + 3)));
endmodule

bind seqdiv_early seqdiv_early_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_seqdiv_early.sv
`timescale 1ns/1ps
module test_seqdiv_early;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // small instance: WIDTH=8, CHUNK=2
  logic       s_start = 1'b0, s_sgn = 1'b0;
  logic [7:0] s_a = '0, s_b = '0;
  logic       s_busy, s_done;
  logic [7:0] s_q, s_r;

  seqdiv_early #(.WIDTH(8), .CHUNK(2)) i_seqdiv_early (
    .clk(clk), .rst(rst), .start(s_start), .sgn_mode(s_sgn),
    .dividend(s_a), .divisor(s_b), .busy(s_busy), .done(s_done),
    .quotient(s_q), .remainder(s_r)
  );

  // wide instance: WIDTH=32, CHUNK=8
  logic        w_start = 1'b0, w_sgn = 1'b0;
  logic [31:0] w_a = '0, w_b = '0;
  logic        w_busy, w_done;
  logic [31:0] w_q, w_r;

  seqdiv_early #(.WIDTH(32), .CHUNK(8)) i_seqdiv_early_wide (
    .clk(clk), .rst(rst), .start(w_start), .sgn_mode(w_sgn),
    .dividend(w_a), .divisor(w_b), .busy(w_busy), .done(w_done),
    .quotient(w_q), .remainder(w_r)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // arithmetic reference
  task automatic model(input int w, input int chunk, input bit sg,
                       input longint a, input longint b,
                       output longint q, output longint r,
                       output int lat, output int iters);
    longint mask, half, sa, sb, ma, mb, qm, rm;
    bit fin, fout, differ;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa = (sg && a >= half) ? a - (longint'(1) << w) : a;
    sb = (sg && b >= half) ? b - (longint'(1) << w) : b;
    iters = w;
    for (int n = w / chunk - 1; n >= 1; n--) begin
      longint lim;
      lim = longint'(1) << (n * chunk);
      if (sg ? (sa >= -(lim / 2) && sa < lim / 2) : (a < lim)) iters = n * chunk + 1;
    end
    fin = sg && (sa < 0 || sb < 0);
    if (b == 0) begin
      q = mask;
      r = a;
      fout = 1'b0;
    end else begin
      ma = (sa < 0) ? -sa : sa;
      mb = (sb < 0) ? -sb : sb;
      qm = ma / mb;
      rm = ma % mb;
      differ = (sa < 0) != (sb < 0);
      q = (differ ? -qm : qm) & mask;
      r = ((sa < 0) ? -rm : rm) & mask;
      fout = sg && ((differ && qm != 0) || (sa < 0 && rm != 0));
    end
    lat = 1 + int'(fin) + iters + int'(fout);
  endtask

  task automatic judge(input int w, input int chunk, input bit sg,
                       input longint a, input longint b,
                       input longint q_obs, input longint r_obs, input int j);
    longint q_exp, r_exp;
    int lat, iters;
    string tq, tl;
    model(w, chunk, sg, a, b, q_exp, r_exp, lat, iters);
    tq = (b == 0) ? "R3 zero divisor" : (sg ? "R2 signed" : "R1 unsigned");
    if (sg && lat != iters + 1) tl = "R6 fixup latency";
    else if (iters < w)         tl = "R5 early-out latency";
    else                        tl = "R4 full latency";
    chk(q_obs == q_exp, {tq, " quotient"}, q_obs, q_exp);
    chk(r_obs == r_exp, {tq, " remainder"}, r_obs, r_exp);
    chk(j == lat, tl, j, lat);
  endtask

  task automatic run_small(input bit sg, input int a, input int b);
    int j;
    @(negedge clk);
    s_start = 1'b1; s_sgn = sg; s_a = 8'(a); s_b = 8'(b);
    @(negedge clk);
    s_start = 1'b0;
    j = 0;
    while (!s_done && j < 40) begin
      @(negedge clk);
      j++;
    end
    judge(8, 2, sg, longint'(a), longint'(b), longint'(s_q), longint'(s_r), j);
  endtask

  task automatic run_wide(input bit sg, input longint a, input longint b);
    int j;
    @(negedge clk);
    w_start = 1'b1; w_sgn = sg; w_a = 32'(a); w_b = 32'(b);
    @(negedge clk);
    w_start = 1'b0;
    chk(w_busy == 1'b1, "R8 busy after accept", longint'(w_busy), 1);
    j = 0;
    while (!w_done && j < 60) begin
      @(negedge clk);
      j++;
    end
    judge(32, 8, sg, a, b, longint'(w_q), longint'(w_r), j);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int divs[12] = '{0, 1, 2, 3, 5, 7, 16, 100, 127, 128, 200, 255};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(s_busy == 1'b0 && s_done == 1'b0, "R9 small control idle", {s_busy, s_done}, 0);
    chk(s_q == 8'h0 && s_r == 8'h0, "R9 small results zero", {s_q, s_r}, 0);
    chk(w_busy == 1'b0 && w_done == 1'b0, "R9 wide control idle", {w_busy, w_done}, 0);
    chk(w_q == 32'h0 && w_r == 32'h0, "R9 wide results zero", {w_q, w_r}, 0);

    // wide directed: full latency and each skip tier (R4, R5)
    run_wide(1'b0, 64'hFFFF_FFFF, 7);
    run_wide(1'b0, 200, 7);
    run_wide(1'b0, 64'h1234, 3);
    run_wide(1'b0, 64'h00AB_CDEF, 5);
    run_wide(1'b0, 64'hDEAD_BEEF, 0);
    // signed corners (R2, R3, R6)
    run_wide(1'b1, 64'h8000_0000, 64'hFFFF_FFFF);
    run_wide(1'b1, 64'hFFFF_FF9C, 7);
    run_wide(1'b1, 100, 0);
    run_wide(1'b1, 64'hFFFF_FFF9, 64'hFFFF_FFFE);
    run_wide(1'b1, 64'h7FFF_FFFF, 64'h8000_0000);
    run_wide(1'b1, 64'hFFFF_FFF0, 0);

    // R7: done lasts one cycle and results hold afterwards
    @(negedge clk);
    chk(w_done == 1'b0, "R7 done single cycle", longint'(w_done), 0);
    chk(w_q == 32'hFFFF_FFFF && w_r == 32'hFFFF_FFF0, "R7 results held",
        {w_q, w_r}, {32'hFFFF_FFFF, 32'hFFFF_FFF0});

    // R8: start while busy is ignored
    begin
      int j;
      @(negedge clk);
      w_start = 1'b1; w_sgn = 1'b0; w_a = 32'd1000; w_b = 32'd7;
      @(negedge clk);
      w_start = 1'b0;
      j = 0;
      repeat (3) begin @(negedge clk); j++; end
      w_start = 1'b1; w_a = 32'd55; w_b = 32'd2;
      @(negedge clk);
      j++;
      w_start = 1'b0;
      while (!w_done && j < 60) begin
        @(negedge clk);
        j++;
      end
      chk(w_q == 32'd142 && w_r == 32'd6, "R8 start while busy ignored",
          {w_q, w_r}, {32'd142, 32'd6});
      chk(j == 18, "R8 busy restart ignored latency", j, 18);
      @(negedge clk);
      chk(w_busy == 1'b0, "R8 second start not taken", longint'(w_busy), 0);
    end

    // small instance: every dividend against a divisor spread, both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        foreach (divs[k]) run_small(m[0], a, divs[k]);
      end
    end

    finish_up();
  end
endmodule